// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block is the serial front end of a small sensor-style device. An external SPI master (clock polarity 0, phase 0) talks to it with fixed 16-bit frames framed by an active-low chip select. The first bits of a frame name one of 64 byte-wide registers and say whether the frame reads or writes it. The second byte carries the data: it comes in on MOSI for a write and goes out on MISO for a read, within the same frame.

The serial pins are not used as clocks. SCK, chip select and MOSI are brought into a faster system clock through two-flop synchronizers, and the block finds the SCK edges there. A write lands in the register array only when all 16 bits have arrived, so a frame cut short by chip select leaves every register as it was. One bit of one register drives an active-high interrupt line towards the master.

Top module: `spi_regport`

## Requirements
- R1: A frame is 16 SCK rising edges while `csb` is low. MOSI bits 1 to 6 give the register address, most significant bit first. Bit 7 is the operation flag, where 1 means write and 0 means read.
- R2: In a write frame, MOSI bits 9 to 16 (most significant bit first) are stored in the addressed register once the 16th rising edge has been taken in.
- R3: In a read frame, the addressed register appears on MISO in bits 9 to 16, most significant bit first. MISO changes after SCK falling edges, so each bit is valid at the following rising edge. A read leaves the register unchanged.
- R4: MISO is 0 during bits 1 to 8 of every frame and during the whole of a write frame.
- R5: The value of MOSI bit 8 has no effect on either operation.
- R6: A frame in which `csb` rises before the 16th rising edge changes no register.
- R7: `miso_oe` is 1 while `csb` is low and 0 while `csb` is high. Each change shows up within four system clocks of the change on `csb`, and MISO reads 0 while `miso_oe` is 0.
- R8: `irq` equals bit `IRQ_BIT` (default 0) of register `IRQ_ADDR` (default 42) and follows a completed write to that register.
- R9: After reset all registers read 0, and `miso`, `miso_oe` and `irq` are 0.
- R10: SCK rising edges after the 16th in the same frame are ignored. They do not alter the register written by that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| csb | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for MISO; 0 means the pad floats |
| irq | output | 1 | Active-high interrupt from a register bit |

## Verification
The assertions assume that SCK, chip select and MOSI are slow compared with the system clock. Each SCK level has to last several system clocks, so that every edge is seen once after synchronization and MISO has settled before the next rising edge. They also assume that chip select changes only while SCK is low. The bench holds each SCK phase for six system clocks and changes MOSI and chip select only while SCK is low. Its random frames keep to these rules, including the frames it cuts short or runs past 16 edges.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  localparam int unsigned SYNC_STAGES = 2;

  // Serial pins as seen from the system clock domain.
  typedef struct packed {
    logic sck;
    logic csb;
    logic mosi;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, csb: 1'b1, mosi: 1'b0};

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_rest
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= RST_VAL;
      else        stg_q[g] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned FRAME_BITS = ADDR_W + DATA_W + 2,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csb_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              rw_flag,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso,
  output logic              miso_oe
);

  localparam int unsigned SH_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam logic [CNT_W-1:0] RW_AT   = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] LOAD_AT = CNT_W'(ADDR_W + 2);
  localparam logic [CNT_W-1:0] LAST_AT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(FRAME_BITS);

  logic              sck_q;
  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic [SH_W-1:0]   shf_q,   shf_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic              rw_q,    rw_d;
  logic [DATA_W-1:0] tx_q,    tx_d;
  logic              miso_q,  miso_d;
  logic              we_q,    we_d;
  logic [DATA_W-1:0] wdat_q,  wdat_d;
  logic              rise, fall;

  assign rise = !csb_s &&  sck_s && !sck_q;
  assign fall = !csb_s && !sck_s &&  sck_q;

  always_comb begin
    cnt_d  = cnt_q;
    shf_d  = shf_q;
    addr_d = addr_q;
    rw_d   = rw_q;
    tx_d   = tx_q;
    miso_d = miso_q;
    we_d   = 1'b0;
    wdat_d = wdat_q;
    if (csb_s) begin
      cnt_d  = '0;
      rw_d   = 1'b0;
      miso_d = 1'b0;
    end else begin
      if (rise && (cnt_q < FULL)) begin
        cnt_d = cnt_q + 1'b1;
        shf_d = {shf_q[SH_W-2:0], mosi_s};
        if (cnt_q == RW_AT) begin
          addr_d = shf_q[ADDR_W-1:0];
          rw_d   = mosi_s;
        end
        if ((cnt_q == LAST_AT) && rw_q) begin
          we_d   = 1'b1;
          wdat_d = {shf_q[DATA_W-2:0], mosi_s};
        end
      end
      if (fall) begin
        if ((cnt_q == LOAD_AT) && !rw_q) begin
          miso_d = rd_data[DATA_W-1];
          tx_d   = rd_data << 1;
        end else if ((cnt_q > LOAD_AT) && (cnt_q < FULL) && !rw_q) begin
          miso_d = tx_q[DATA_W-1];
          tx_d   = tx_q << 1;
        end else begin
          miso_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      shf_q  <= '0;
      addr_q <= '0;
      rw_q   <= 1'b0;
      tx_q   <= '0;
      miso_q <= 1'b0;
      we_q   <= 1'b0;
      wdat_q <= '0;
    end else begin
      sck_q  <= sck_s;
      cnt_q  <= cnt_d;
      shf_q  <= shf_d;
      addr_q <= addr_d;
      rw_q   <= rw_d;
      tx_q   <= tx_d;
      miso_q <= miso_d;
      we_q   <= we_d;
      wdat_q <= wdat_d;
    end
  end

  assign addr    = addr_q;
  assign rw_flag = rw_q;
  assign bit_cnt = cnt_q;
  assign wr_en   = we_q;
  assign wr_data = wdat_q;
  assign miso    = miso_q;
  assign miso_oe = !csb_s;

endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IRQ_ADDR = 42,
  parameter int unsigned IRQ_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
  assign irq     = mem_q[IRQ_ADDR][IRQ_BIT];

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IRQ_ADDR = 42,
  parameter int unsigned IRQ_BIT  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csb,
  input  logic mosi,
  output logic miso,
  output logic miso_oe,
  output logic irq
);

  import spi_regport_pkg::*;

  localparam int unsigned FRAME_BITS = ADDR_W + DATA_W + 2;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  spi_pins_t pins_raw, pins_s;
  assign pins_raw = '{sck: sck, csb: csb, mosi: mosi};

  spi_regport_sync #(
    .WIDTH   ($bits(spi_pins_t)),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  logic [ADDR_W-1:0] frm_addr;
  logic              frm_rw;
  logic [CNT_W-1:0]  frm_cnt;
  logic              frm_we;
  logic [DATA_W-1:0] frm_wdata;
  logic [DATA_W-1:0] reg_rdata;

  spi_regport_frame #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) frame_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sck_s   (pins_s.sck),
    .csb_s   (pins_s.csb),
    .mosi_s  (pins_s.mosi),
    .rd_data (reg_rdata),
    .addr    (frm_addr),
    .rw_flag (frm_rw),
    .bit_cnt (frm_cnt),
    .wr_en   (frm_we),
    .wr_data (frm_wdata),
    .miso    (miso),
    .miso_oe (miso_oe)
  );

  spi_regport_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IRQ_ADDR (IRQ_ADDR),
    .IRQ_BIT  (IRQ_BIT)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (frm_we),
    .wr_addr (frm_addr),
    .wr_data (frm_wdata),
    .rd_addr (frm_addr),
    .rd_data (reg_rdata),
    .irq     (irq)
  );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IRQ_ADDR = 42,
  parameter int unsigned IRQ_BIT  = 0,
  parameter int unsigned CNT_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csb,
  input logic              miso,
  input logic              miso_oe,
  input logic              irq,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              rw_flag,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);

  localparam logic [CNT_W-1:0] FULL    = CNT_W'(ADDR_W + DATA_W + 2);
  localparam logic [CNT_W-1:0] LOAD_AT = CNT_W'(ADDR_W + 2);

  // Consecutive cycles with chip select high, saturating at 3.
  logic [1:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_run_q <= 2'd0;
    else if (!csb)       hi_run_q <= 2'd0;
    else if (hi_run_q != 2'd3) hi_run_q <= hi_run_q + 2'd1;
  end

  assert_cnt_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);

  assert_hdr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt < LOAD_AT) |-> !miso);

  assert_wr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rw_flag |-> !miso);

  assert_commit_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (rw_flag && (bit_cnt == FULL)));

  assert_idle_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_run_q == 2'd3) |-> (!miso_oe && !miso));

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq) |-> $past(wr_en));

  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADDR_W'(IRQ_ADDR))) |=> (irq == $past(wr_data[IRQ_BIT])));

endmodule

bind spi_regport spi_regport_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .IRQ_ADDR (IRQ_ADDR),
  .IRQ_BIT  (IRQ_BIT),
  .CNT_W    (CNT_W)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .csb     (csb),
  .miso    (miso),
  .miso_oe (miso_oe),
  .irq     (irq),
  .bit_cnt (frm_cnt),
  .rw_flag (frm_rw),
  .wr_en   (frm_we),
  .wr_addr (frm_addr),
  .wr_data (frm_wdata)
);

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;

  localparam int HALF     = 6;
  localparam int IRQ_ADDR = 42;

  logic clk;
  logic rst_n;
  logic sck;
  logic csb;
  logic mosi;
  logic miso;
  logic miso_oe;
  logic irq;

  int total = 0;
  int bad   = 0;
  bit reported = 0;

  logic [7:0] model [64];

  spi_regport dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck     (sck),
    .csb     (csb),
    .mosi    (mosi),
    .miso    (miso),
    .miso_oe (miso_oe),
    .irq     (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [15:0] make_frame(input logic [5:0] a, input logic rw,
                                             input logic b8, input logic [7:0] d);
    return {a, rw, b8, d};
  endfunction

  // One frame of nbits SCK cycles; returns the byte seen on MISO in bits 9..16.
  task automatic xfer(input logic [5:0] a, input logic rw, input logic [7:0] d,
                      input logic b8, input int nbits, output logic [7:0] rd);
    logic [15:0] fr;
    int quiet_bad;
    int oe_bad;
    fr = make_frame(a, rw, b8, d);
    rd = 8'h00;
    quiet_bad = 0;
    oe_bad = 0;
    csb = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? fr[15-i] : 1'($urandom);
      repeat (HALF) @(negedge clk);
      if (!miso_oe) oe_bad++;
      if ((i < 8 || rw) && miso) quiet_bad++;
      if (i >= 8 && i < 16) rd = {rd[6:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csb = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);
    chk(quiet_bad == 0, "R4 miso quiet", quiet_bad, 0);
    chk(oe_bad == 0, "R7 oe in frame", oe_bad, 0);
    chk(!miso_oe && !miso, "R7 oe after frame", {miso_oe, miso}, 0);
    if (nbits >= 16 && rw) model[a] = d;
    chk(irq == model[IRQ_ADDR][0], "R8 irq", irq, model[IRQ_ADDR][0]);
  endtask

  task automatic do_read(input logic [5:0] a, input logic b8, input int nbits, input string req);
    logic [7:0] r;
    xfer(a, 1'b0, 8'($urandom), b8, nbits, r);
    if (nbits >= 16) chk(r == model[a], req, r, model[a]);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d, input logic b8, input int nbits);
    logic [7:0] r;
    xfer(a, 1'b1, d, b8, nbits, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    rst_n = 1'b0;
    sck = 1'b0;
    csb = 1'b1;
    mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: reset state
    chk(!miso && !miso_oe && !irq, "R9 reset outputs", {miso, miso_oe, irq}, 0);
    do_read(6'd0,  1'b0, 16, "R9 reset reg 0");
    do_read(6'd63, 1'b0, 16, "R9 reset reg 63");
    do_read(6'(IRQ_ADDR), 1'b0, 16, "R9 reset irq reg");

    // R1/R2/R3: basic write then read, plus address boundaries
    do_write(6'h15, 8'hA5, 1'b0, 16);
    do_read(6'h15, 1'b0, 16, "R2 R3 readback 0x15");
    do_read(6'h15, 1'b0, 16, "R3 read leaves value");
    do_write(6'd0,  8'hFF, 1'b0, 16);
    do_write(6'd63, 8'h01, 1'b0, 16);
    do_read(6'd0,  1'b0, 16, "R1 addr 0");
    do_read(6'd63, 1'b0, 16, "R1 addr 63");
    do_read(6'h15, 1'b0, 16, "R1 neighbour untouched");

    // R5: bit 8 ignored
    do_write(6'h22, 8'h3C, 1'b1, 16);
    do_read(6'h22, 1'b1, 16, "R5 bit8 set on both");
    do_read(6'h22, 1'b0, 16, "R5 bit8 clear on read");

    // R6: aborted frames
    do_write(6'h15, 8'h5A, 1'b0, 15);
    do_read(6'h15, 1'b0, 16, "R6 abort after 15");
    do_write(6'h15, 8'h00, 1'b0, 7);
    do_read(6'h15, 1'b0, 16, "R6 abort after 7");

    // R10: extra SCK edges after bit 16
    do_write(6'h10, 8'h96, 1'b0, 20);
    do_read(6'h10, 1'b0, 16, "R10 overlong write");
    do_read(6'h10, 1'b0, 21, "R10 overlong read");
    do_read(6'h10, 1'b0, 16, "R10 after overlong read");

    // R8: interrupt bit set and cleared
    do_write(6'(IRQ_ADDR), 8'h01, 1'b0, 16);
    chk(irq == 1'b1, "R8 irq set", irq, 1);
    do_write(6'(IRQ_ADDR), 8'hFE, 1'b0, 16);
    chk(irq == 1'b0, "R8 irq clear", irq, 0);

    // Random mix, some frames cut short
    for (int n = 0; n < 80; n++) begin
      logic [5:0] a;
      int nb;
      a  = ((n % 4) == 0) ? 6'(IRQ_ADDR) : 6'($urandom);
      nb = (($urandom % 8) == 0) ? int'(1 + ($urandom % 15)) : 16;
      if ($urandom % 2) do_write(a, 8'($urandom), 1'($urandom), nb);
      else              do_read(a, 1'($urandom), nb, "R3 random read");
    end
    for (int i = 0; i < 64; i += 9) do_read(6'(i), 1'b0, 16, "R2 final sweep");

    report();
  end

endmodule